// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front End

This block is the command side of a small serial nonvolatile memory, seen from an SPI bus in mode 0. A host lowers chip select and clocks in an opcode byte. Depending on the opcode, it then sends a two-byte address and data bytes, or clocks a reply out on the serial output. The block decodes these instructions:
- set and clear a write-enable latch;
- set and clear a general-purpose flag;
- read and write a status byte;
- read and write a byte array, with the address stepping forward after each byte.

Each SPI line passes through a two-flop synchronizer and is sampled by the system clock. SCK must therefore stay high and stay low for at least 12 system clock cycles in each phase.

An array write goes into a one-page staging buffer first. It is committed to the internal array only when chip select rises on a byte boundary. The commit starts a busy period of a fixed, parameterized number of cycles, which stands in for the cell programming time. The status write is committed the same way. While the block is busy, the write-in-progress bit reads 1 and only the status read instruction is honoured.

Top module: `spi_eeprom_frontend`

## Requirements
- R1: `so_oe` is 0 whenever `cs_n` has been high for three or more clock cycles. It is 1 while `cs_n` is low, from the third cycle after `cs_n` falls. While `so_oe` is 0, `so` is meaningless.
- R2: Opcodes, addresses and data travel most significant bit first. SI is sampled on SCK rising edges and SO changes after SCK falling edges. SCK may stop at any level for any time inside a frame, and the transfer continues correctly when clocking resumes.
- R3: The status byte is laid out as follows:
  - bit 7: protect-enable bit;
  - bit 6: flag;
  - bits 5:4: always 1;
  - bits 3:2: two block bits;
  - bit 1: write-enable latch;
  - bit 0: write in progress.

  Opcode 0x06 sets the latch, opcode 0x00 sets the flag, and opcode 0x04 clears both the latch and the flag. After reset the status reads 0x30.
- R4: Opcode 0x05 makes SO return the current status byte in every following byte of the frame. This also holds while a write is in progress.
- R5: Opcode 0x03 takes two address bytes, of which only the low ADDR_W bits count. It then returns the array byte at that address, then the next address, and so on. The address wraps from the last location to 0.
- R6: Opcode 0x02 with the latch set takes two address bytes and then data bytes. The address wraps inside the 2^PAGE_W byte page, and a later byte replaces an earlier one at the same location. The bytes reach the array only if chip select rises after one or more whole data bytes.
- R7: If chip select rises partway through a byte, or before any data byte, a pending array or status write is dropped. The array and status stay unchanged, no busy period starts, and the latch stays set.
- R8: Opcodes 0x02 and 0x01 are ignored while the latch is clear.
- R9: A committed write holds write-in-progress high for exactly BUSY_CYCLES clock cycles. The latch reads 0 once the busy period ends.
- R10: While write-in-progress is high, every opcode except 0x05 is ignored for the rest of its frame. Such an opcode changes no latch or flag, and a read returns zeros on SO.
- R11: An opcode outside the set listed in R3–R6, R8 and R12 causes the rest of its frame to be ignored.
- R12: Opcode 0x01 with the latch set takes a data byte whose bits 7, 6, 3 and 2 go to the matching status bits when chip select rises, and it starts a busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI lines are sampled by it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; a rising edge ends the frame |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; 0 means the pad should float |

## Verification
The hardest state to reach is the busy window. Checking that commands are ignored there, and that status still answers, requires whole SPI frames to complete inside the programming delay. For this reason the bench uses a BUSY_CYCLES long enough to fit several frames. Right after each commit it issues latch, flag and read commands followed by status reads, then polls status until write-in-progress drops. The aborted-write case needs chip select raised with only a few bits of a byte clocked. To cover it, the bench has a partial-byte transfer task that stops after a chosen number of edges.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_SET_FLAG   = 8'h00;
  localparam logic [7:0] OP_WR_STATUS  = 8'h01;
  localparam logic [7:0] OP_WR_ARRAY   = 8'h02;
  localparam logic [7:0] OP_RD_ARRAY   = 8'h03;
  localparam logic [7:0] OP_CLR_LATCH  = 8'h04;
  localparam logic [7:0] OP_RD_STATUS  = 8'h05;
  localparam logic [7:0] OP_SET_LATCH  = 8'h06;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_READ,
    PH_WRITE,
    PH_STATUS_IN,
    PH_STATUS_OUT,
    PH_DISCARD
  } phase_e;

endpackage

// File: rtl/spi_shift_port.sv
module spi_shift_port
  import eeprom_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              frame_end,
  output logic              frame_partial,
  output logic              so,
  output logic              so_oe
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [1:0]        cs_s, sck_s, si_s;
  logic              sck_prev, cs_prev;
  logic              sel, rise, fall, cs_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] tx_sr;

  assign sel     = ~cs_s[1];
  assign rise    = sel &  sck_s[1] & ~sck_prev;
  assign fall    = sel & ~sck_s[1] &  sck_prev;
  assign cs_rise = cs_s[1] & ~cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s          <= 2'b11;
      sck_s         <= 2'b00;
      si_s          <= 2'b00;
      sck_prev      <= 1'b0;
      cs_prev       <= 1'b1;
      bit_cnt       <= '0;
      shreg         <= '0;
      tx_sr         <= '0;
      rx_byte       <= '0;
      rx_valid      <= 1'b0;
      frame_end     <= 1'b0;
      frame_partial <= 1'b0;
      so            <= 1'b0;
      so_oe         <= 1'b0;
    end else begin
      cs_s          <= {cs_s[0], cs_n};
      sck_s         <= {sck_s[0], sck};
      si_s          <= {si_s[0], si};
      sck_prev      <= sck_s[1];
      cs_prev       <= cs_s[1];
      rx_valid      <= 1'b0;
      frame_end     <= cs_rise;
      frame_partial <= cs_rise & (bit_cnt != '0);
      so_oe         <= sel;
      if (!sel) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
        so      <= 1'b0;
      end else begin
        if (rise) begin
          shreg   <= {shreg[BYTE_W-3:0], si_s[1]};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            rx_byte  <= {shreg, si_s[1]};
            rx_valid <= 1'b1;
          end
        end
        if (tx_load) begin
          tx_sr <= tx_data;
        end else if (fall) begin
          so    <= tx_sr[BYTE_W-1];
          tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] remain;

  assign finish = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/mem_array.sv
module mem_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              frame_end,
  input  logic              frame_partial,
  input  logic              busy,
  input  logic              finish,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_data,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              busy_start,
  output logic              wel
);

  localparam int PAGE_N = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  phase_e            phase;
  logic              flag, prot_en, is_write, got_byte;
  logic [1:0]        blk;
  logic [BYTE_W-1:0] addr_hi;
  logic [ADDR_W-1:0] addr_in, rd_ptr;
  logic [BASE_W-1:0] page_base;
  logic [PAGE_W-1:0] wr_ptr, commit_idx;
  logic [PAGE_N-1:0] page_vld;
  logic [BYTE_W-1:0] page_buf [PAGE_N];
  logic              commit_on, rd_p1, rd_p2;
  logic              new_prot, new_flag;
  logic [1:0]        new_blk;
  logic [BYTE_W-1:0] status_byte;

  assign addr_in     = ADDR_W'({addr_hi, rx_byte});
  assign status_byte = {prot_en, flag, 2'b11, blk, wel, busy};

  // staging page: plain array, no reset, one write port
  always_ff @(posedge clk) begin
    if (rx_valid && !frame_end && phase == PH_WRITE)
      page_buf[wr_ptr] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_OPCODE;
      wel        <= 1'b0;
      flag       <= 1'b0;
      prot_en    <= 1'b0;
      blk        <= 2'b00;
      is_write   <= 1'b0;
      got_byte   <= 1'b0;
      addr_hi    <= '0;
      rd_ptr     <= '0;
      page_base  <= '0;
      wr_ptr     <= '0;
      page_vld   <= '0;
      commit_on  <= 1'b0;
      commit_idx <= '0;
      rd_p1      <= 1'b0;
      rd_p2      <= 1'b0;
      new_prot   <= 1'b0;
      new_flag   <= 1'b0;
      new_blk    <= 2'b00;
      tx_load    <= 1'b0;
      tx_data    <= '0;
      mem_re     <= 1'b0;
      mem_raddr  <= '0;
      mem_we     <= 1'b0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
      busy_start <= 1'b0;
    end else begin
      tx_load    <= 1'b0;
      busy_start <= 1'b0;
      mem_re     <= 1'b0;
      mem_we     <= 1'b0;
      rd_p1      <= 1'b0;
      rd_p2      <= rd_p1;

      // array data is valid two cycles after the read request
      if (rd_p2) begin
        tx_load <= 1'b1;
        tx_data <= rd_data;
      end

      if (finish) wel <= 1'b0;

      // drain the staging page into the array during the busy period
      if (commit_on) begin
        if (page_vld[commit_idx]) begin
          mem_we    <= 1'b1;
          mem_waddr <= {page_base, commit_idx};
          mem_wdata <= page_buf[commit_idx];
        end
        commit_idx <= commit_idx + 1'b1;
        if (commit_idx == '1) commit_on <= 1'b0;
      end

      if (frame_end) begin
        phase    <= PH_OPCODE;
        got_byte <= 1'b0;
        if (!frame_partial && got_byte) begin
          if (phase == PH_WRITE) begin
            commit_on  <= 1'b1;
            commit_idx <= '0;
            busy_start <= 1'b1;
          end
          if (phase == PH_STATUS_IN) begin
            prot_en    <= new_prot;
            flag       <= new_flag;
            blk        <= new_blk;
            busy_start <= 1'b1;
          end
        end
      end else if (rx_valid) begin
        unique case (phase)
          PH_OPCODE: begin
            if (busy && rx_byte != OP_RD_STATUS) begin
              phase <= PH_DISCARD;
            end else begin
              case (rx_byte)
                OP_SET_LATCH: begin
                  wel   <= 1'b1;
                  phase <= PH_DISCARD;
                end
                OP_CLR_LATCH: begin
                  wel   <= 1'b0;
                  flag  <= 1'b0;
                  phase <= PH_DISCARD;
                end
                OP_SET_FLAG: begin
                  flag  <= 1'b1;
                  phase <= PH_DISCARD;
                end
                OP_RD_STATUS: begin
                  tx_load <= 1'b1;
                  tx_data <= status_byte;
                  phase   <= PH_STATUS_OUT;
                end
                OP_WR_STATUS: phase <= wel ? PH_STATUS_IN : PH_DISCARD;
                OP_RD_ARRAY: begin
                  is_write <= 1'b0;
                  phase    <= PH_ADDR_HI;
                end
                OP_WR_ARRAY: begin
                  if (wel) begin
                    is_write <= 1'b1;
                    page_vld <= '0;
                    phase    <= PH_ADDR_HI;
                  end else begin
                    phase <= PH_DISCARD;
                  end
                end
                default: phase <= PH_DISCARD;
              endcase
            end
          end
          PH_ADDR_HI: begin
            addr_hi <= rx_byte;
            phase   <= PH_ADDR_LO;
          end
          PH_ADDR_LO: begin
            if (is_write) begin
              page_base <= addr_in[ADDR_W-1:PAGE_W];
              wr_ptr    <= addr_in[PAGE_W-1:0];
              phase     <= PH_WRITE;
            end else begin
              mem_re    <= 1'b1;
              mem_raddr <= addr_in;
              rd_ptr    <= addr_in + 1'b1;
              rd_p1     <= 1'b1;
              phase     <= PH_READ;
            end
          end
          PH_READ: begin
            mem_re    <= 1'b1;
            mem_raddr <= rd_ptr;
            rd_ptr    <= rd_ptr + 1'b1;
            rd_p1     <= 1'b1;
          end
          PH_WRITE: begin
            page_vld[wr_ptr] <= 1'b1;
            wr_ptr           <= wr_ptr + 1'b1;
            got_byte         <= 1'b1;
          end
          PH_STATUS_IN: begin
            if (!got_byte) begin
              new_prot <= rx_byte[7];
              new_flag <= rx_byte[6];
              new_blk  <= rx_byte[3:2];
              got_byte <= 1'b1;
            end
          end
          PH_STATUS_OUT: begin
            tx_load <= 1'b1;
            tx_data <= status_byte;
          end
          PH_DISCARD: ;
          default: phase <= PH_DISCARD;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_eeprom_frontend.sv
module spi_eeprom_frontend
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);

  logic [BYTE_W-1:0] rx_byte, tx_data, mem_wdata, mem_rdata;
  logic              rx_valid, frame_end, frame_partial, tx_load;
  logic              busy_w, finish_w, busy_start_w, wel_w;
  logic              mem_re, mem_we_w;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;

  spi_shift_port u_port (
    .clk           (clk),
    .rst           (rst),
    .cs_n          (cs_n),
    .sck           (sck),
    .si            (si),
    .tx_load       (tx_load),
    .tx_data       (tx_data),
    .rx_byte       (rx_byte),
    .rx_valid      (rx_valid),
    .frame_end     (frame_end),
    .frame_partial (frame_partial),
    .so            (so),
    .so_oe         (so_oe)
  );

  cmd_sequencer #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .rx_byte       (rx_byte),
    .rx_valid      (rx_valid),
    .frame_end     (frame_end),
    .frame_partial (frame_partial),
    .busy          (busy_w),
    .finish        (finish_w),
    .rd_data       (mem_rdata),
    .tx_load       (tx_load),
    .tx_data       (tx_data),
    .mem_re        (mem_re),
    .mem_raddr     (mem_raddr),
    .mem_we        (mem_we_w),
    .mem_waddr     (mem_waddr),
    .mem_wdata     (mem_wdata),
    .busy_start    (busy_start_w),
    .wel           (wel_w)
  );

  busy_timer #(
    .CYCLES (BUSY_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (busy_start_w),
    .busy   (busy_w),
    .finish (finish_w)
  );

  mem_array #(
    .AW (ADDR_W),
    .DW (BYTE_W)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we_w),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/spi_eeprom_frontend_checker.sv
module spi_eeprom_frontend_checker #(
  parameter int BUSY_CYCLES = 2000
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic so_oe,
  input logic busy,
  input logic wel,
  input logic mem_we,
  input logic busy_start
);

  localparam int LEN_W = $clog2(BUSY_CYCLES + 2);

  logic [1:0]       age;
  logic             armed;
  logic [LEN_W-1:0] busy_len;

  assign armed = (age == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= '0;
      busy_len <= '0;
    end else begin
      if (!armed) age <= age + 1'b1;
      busy_len <= busy ? busy_len + 1'b1 : '0;
    end
  end

  // R1: output enable released once chip select has been high long enough
  a_r1_so_released: assert property (@(posedge clk) disable iff (rst)
    (armed && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  // R9: busy period lasts exactly the configured count
  a_r9_busy_length: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(busy)) |-> (busy_len == LEN_W'(BUSY_CYCLES)));

  // R9: latch is clear when the busy period ends
  a_r9_latch_cleared: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(busy)) |-> !wel);

  // R6: array cells change only inside the busy period
  a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R8: a busy period is only entered with the latch set
  a_r8_busy_needs_latch: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(busy)) |-> $past(wel));

  // R10: no new commit is requested while busy
  a_r10_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy_start |-> !busy);

endmodule

bind spi_eeprom_frontend spi_eeprom_frontend_checker #(
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .so_oe      (so_oe),
  .busy       (busy_w),
  .wel        (wel_w),
  .mem_we     (mem_we_w),
  .busy_start (busy_start_w)
);

// File: tb/spi_eeprom_frontend_test.sv
module spi_eeprom_frontend_test;

  localparam int ADDR_W = 6;
  localparam int PAGE_W = 4;
  localparam int BUSY   = 3000;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HALF   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so, so_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] shadow [DEPTH];

  always #5 clk = ~clk;

  spi_eeprom_frontend #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .BUSY_CYCLES (BUSY)
  ) uut (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .sck   (sck),
    .si    (si),
    .so    (so),
    .so_oe (so_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // nbits < 8 stops early; pause_at inserts a long idle before that bit's rise
  task automatic xfer_bits(input logic [7:0] tx, input int nbits, input int pause_at,
                           output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      si = tx[i];
      tick(HALF);
      if (i == pause_at) tick(300);
      rx[i] = so;
      sck = 1'b1;
      tick(HALF);
      if (i == pause_at) tick(300);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, -1, rx);
  endtask

  task automatic put(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, dummy);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    cs_n = 1'b1;
    tick(4 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    sel(); put(op); desel();
  endtask

  task automatic rd_status(output logic [7:0] s);
    sel(); put(8'h05); xfer(8'h00, s); desel();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      rd_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic rd_byte(input int a, output logic [7:0] d);
    sel(); put(8'h03); put(8'h00); put(8'(a)); xfer(8'h00, d); desel();
  endtask

  function automatic logic [7:0] pat(input int a, input int pass);
    return 8'((a * 37 + pass * 91 + 5) & 255);
  endfunction

  task automatic page_write(input int base, input int off, input int n, input int pass);
    logic [7:0] s;
    int a;
    cmd(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'(base + off));
    for (int k = 0; k < n; k++) begin
      a = base + ((off + k) % PAGE_N);
      put(pat(a, pass));
      shadow[a] = pat(a, pass);
    end
    desel();
    rd_status(s);
    chk("R9 write in progress and latch during busy", s, 8'h33);
    wait_idle();
    rd_status(s);
    chk("R9 latch cleared after busy", s, 8'h30);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] s, d;
    for (int a = 0; a < DEPTH; a++) shadow[a] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(5);

    // R1: released at reset, driven while selected, released again after
    chk("R1 so_oe idle after reset", {7'd0, so_oe}, 8'h00);
    cs_n = 1'b0; tick(4);
    chk("R1 so_oe while selected", {7'd0, so_oe}, 8'h01);
    cs_n = 1'b1; tick(4);
    chk("R1 so_oe after deselect", {7'd0, so_oe}, 8'h00);

    // R3, R4: reset status, repeated status bytes in one frame
    sel(); put(8'h05);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, s);
      chk("R4 repeated status byte", s, 8'h30);
    end
    desel();

    // R3: latch and flag opcodes
    cmd(8'h00); rd_status(s); chk("R3 flag set", s, 8'h70);
    cmd(8'h06); rd_status(s); chk("R3 latch set", s, 8'h72);
    cmd(8'h04); rd_status(s); chk("R3 0x04 clears latch and flag", s, 8'h30);

    // R11: unknown opcode swallows the rest of the frame
    sel(); put(8'hA5); put(8'h06); put(8'h00); desel();
    rd_status(s); chk("R11 unknown opcode ignored", s, 8'h30);

    // R8: writes with the latch clear
    sel(); put(8'h02); put(8'h00); put(8'h03); put(8'h5A); desel();
    rd_status(s); chk("R8 array write without latch", s, 8'h30);
    sel(); put(8'h01); put(8'hCC); desel();
    rd_status(s); chk("R8 status write without latch", s, 8'h30);

    // R6: page sweep, every page, different start offsets
    for (int p = 0; p < DEPTH / PAGE_N; p++)
      page_write(p * PAGE_N, (p * 5) % PAGE_N, PAGE_N, p);
    // R6: 20 bytes into one page, wrap overwrites the first four
    page_write(PAGE_N, 14, 20, 9);

    // R5: read whole array starting near the top, upper address bits ignored
    sel(); put(8'h03); put(8'hFF); put(8'hFE);
    for (int k = 0; k < DEPTH + 6; k++) begin
      xfer(8'h00, d);
      chk("R5 sequential read with wrap", d, shadow[(62 + k) % DEPTH]);
    end
    desel();
    rd_byte(3, d); chk("R8 array unchanged", d, shadow[3]);

    // R2: clock paused mid-byte, mid-read
    sel(); put(8'h03); put(8'h00); put(8'h05);
    xfer_bits(8'h00, 8, 4, d); chk("R2 read across paused clock", d, shadow[5]);
    xfer(8'h00, d);            chk("R2 next byte after pause", d, shadow[6]);
    desel();

    // R7: chip select rises mid-byte, and with no data byte
    cmd(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'h08); put(8'hAA); xfer_bits(8'h55, 3, -1, d); desel();
    rd_status(s); chk("R7 partial byte: no busy, latch kept", s, 8'h32);
    rd_byte(8, d); chk("R7 array unchanged after abort", d, shadow[8]);
    sel(); put(8'h02); put(8'h00); put(8'h09); desel();
    rd_status(s); chk("R7 no data byte: no busy", s, 8'h32);
    sel(); put(8'h01); xfer_bits(8'hCC, 5, -1, d); desel();
    rd_status(s); chk("R7 partial status write dropped", s, 8'h32);
    cmd(8'h04);

    // R10: commands during busy are ignored
    cmd(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'd40); put(8'h77); desel();
    shadow[40] = 8'h77;
    cmd(8'h04); rd_status(s); chk("R10 latch clear ignored while busy", s, 8'h33);
    cmd(8'h00); rd_status(s); chk("R10 flag set ignored while busy", s, 8'h33);
    sel(); put(8'h03); put(8'h00); put(8'd40); xfer(8'h00, d); desel();
    chk("R10 read ignored while busy", d, 8'h00);
    wait_idle();
    rd_status(s); chk("R10 status after busy", s, 8'h30);
    rd_byte(40, d); chk("R6 single byte commit", d, 8'h77);

    // R12: status write
    cmd(8'h06);
    sel(); put(8'h01); put(8'hCC); put(8'h00); desel();
    rd_status(s); chk("R12 status write during busy", s, 8'hFF);
    wait_idle();
    rd_status(s); chk("R12 status bits kept", s, 8'hFC);
    cmd(8'h06);
    sel(); put(8'h01); put(8'h00); desel();
    wait_idle();
    rd_status(s); chk("R12 status bits cleared", s, 8'h30);

    // R6, R5: final full readback of the array
    sel(); put(8'h03); put(8'h00); put(8'h00);
    for (int a = 0; a < DEPTH; a++) begin
      xfer(8'h00, d);
      chk("R6 final array contents", d, shadow[a]);
    end
    desel();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule